// File: doc/BRIEF.md
# Guest Event Injection Arbiter

At every guest-entry boundary this block picks exactly one pending event to deliver and encodes it as a 32-bit injection word. The candidates, in order of precedence, are an event being re-delivered after an aborted entry, a hardware exception, a system-management interrupt, a non-maskable interrupt and a maskable external interrupt. A lower event that loses arbitration is not dropped. It stays pending at its source and competes again at the next entry.

A maskable interrupt may only be delivered when the guest's interrupt flag is set and no one-instruction shadow is active. The shadow follows an interrupt-enable instruction or a stack-segment load. If the maskable interrupt is the top pending event but is blocked, the block injects nothing and raises a window-exit request. When the environment reports that the window has opened, the request drops and a one-cycle re-check strobe tells the surrounding logic to run the event check again. A one-cycle acknowledge tells the interrupt source that its vector was consumed. Two saturating counters track injected maskable interrupts and serviced window exits.

Top module: `evt_inj_arb`

## Requirements
- R1: Precedence among pending events is re-delivered event, then exception, then system-management interrupt, then non-maskable interrupt, then maskable interrupt. The event taken at an entry is the highest-ranked pending one.
- R2: At most one event is taken per entry. When a higher event is taken, `intr_ack_o` and `smi_go_o` stay low for all lower events.
- R3: A maskable interrupt is blocked when `if_flag_i` is 0, or `sti_shadow_i` is 1, or `ss_shadow_i` is 1. A blocked interrupt is never placed in the injection word.
- R4: If the maskable interrupt is the highest pending event at an entry and is blocked, `win_req_o` is 1 from the following cycle, the injection word has its valid bit at 0, and no acknowledge is given.
- R5: When `win_exit_i` is high while `win_req_o` is 1, `win_req_o` falls and `recheck_o` is high for exactly the next cycle. A window exit while `win_req_o` is 0 has no effect. An arming entry in the same cycle as an exit keeps `win_req_o` at 1.
- R6: The injection word has bit 31 as valid, bits 10:8 as type, bits 7:0 as vector, and all other bits 0. Type 0 means external interrupt with `intr_vec_i`. Type 2 means NMI with vector 2. Type 3 means hardware exception with `exc_vec_i`. A re-delivered event carries `reinj_type_i` and `reinj_vec_i` unchanged.
- R7: `intr_ack_o` is high for one cycle, the cycle after an entry whose injection word carries the maskable interrupt, and at no other time. Injecting the maskable interrupt also clears `win_req_o`.
- R8: A system-management interrupt is taken by pulsing `smi_go_o` for one cycle. The injection word for that entry has valid at 0.
- R9: `inj_cnt_o` counts maskable-interrupt injections and `win_cnt_o` counts window exits taken while a request is armed. Both stop at 2^CNT_W-1.
- R10: After reset, every output is 0.
- R11: The injection word changes only at an entry. Between entries it holds its value whatever the inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| entry_i | input | 1 | Guest-entry boundary strobe |
| reinj_pend_i | input | 1 | Re-delivered event pending |
| reinj_type_i | input | 3 | Type of re-delivered event |
| reinj_vec_i | input | 8 | Vector of re-delivered event |
| exc_pend_i | input | 1 | Exception pending |
| exc_vec_i | input | 8 | Exception vector |
| smi_pend_i | input | 1 | System-management interrupt pending |
| nmi_pend_i | input | 1 | Non-maskable interrupt pending |
| intr_pend_i | input | 1 | Maskable interrupt pending |
| intr_vec_i | input | 8 | Maskable interrupt vector |
| if_flag_i | input | 1 | Guest interrupt flag |
| sti_shadow_i | input | 1 | Shadow after interrupt-enable instruction |
| ss_shadow_i | input | 1 | Shadow after stack-segment load |
| win_exit_i | input | 1 | Interrupt window has opened |
| inj_word_o | output | 32 | Injection word |
| intr_ack_o | output | 1 | Maskable vector consumed |
| smi_go_o | output | 1 | System-management interrupt taken |
| win_req_o | output | 1 | Window-exit request armed |
| recheck_o | output | 1 | Re-run event check |
| win_cnt_o | output | CNT_W | Saturating window-exit count |
| inj_cnt_o | output | CNT_W | Saturating maskable-injection count |

## Verification
The bench builds the block with CNT_W set to 3, so both counters reach their ceiling of 7 after a handful of injections and window exits. That makes the saturation of R9 observable in a few dozen cycles. With the default width, a run would need hundreds of injections to reach the ceiling. The remaining checks cover each precedence pairing, each of the three blocking conditions, an arming entry in the same cycle as an exit, and word holding between entries. None of these depend on the counter width.

// File: rtl/evt_inj_pkg.sv
package evt_inj_pkg;

  localparam int unsigned NUM_EVT = 5;
  localparam int unsigned SEL_W   = $clog2(NUM_EVT + 1);

  // index equals rank, 0 is highest
  localparam int unsigned IDX_REINJ = 0;
  localparam int unsigned IDX_EXC   = 1;
  localparam int unsigned IDX_SMI   = 2;
  localparam int unsigned IDX_NMI   = 3;
  localparam int unsigned IDX_INTR  = 4;

  localparam logic [2:0] TY_EXT   = 3'd0;
  localparam logic [2:0] TY_NMI   = 3'd2;
  localparam logic [2:0] TY_HWEXC = 3'd3;
  localparam logic [7:0] NMI_VEC  = 8'd2;

  typedef struct packed {
    logic        valid;
    logic [19:0] rsvd;
    logic [2:0]  ty;
    logic [7:0]  vec;
  } inj_word_t;

  function automatic inj_word_t mk_word(input logic [2:0] ty, input logic [7:0] vec);
    inj_word_t w;
    w.valid = 1'b1;
    w.rsvd  = '0;
    w.ty    = ty;
    w.vec   = vec;
    return w;
  endfunction

endpackage

// File: rtl/evt_prio_sel.sv
module evt_prio_sel
  import evt_inj_pkg::*;
#(
  parameter int unsigned N = NUM_EVT
) (
  input  logic [N-1:0] pend_i,
  output logic [N-1:0] grant_o,
  output logic         any_o
);

  logic [N-1:0] higher;

  // higher[k]: some event of rank below k is pending
  assign higher[0] = 1'b0;
  for (genvar k = 1; k < N; k++) begin : g_chain
    assign higher[k] = higher[k-1] | pend_i[k-1];
  end

  for (genvar k = 0; k < N; k++) begin : g_grant
    assign grant_o[k] = pend_i[k] & ~higher[k];
  end

  assign any_o = |pend_i;

endmodule

// File: rtl/evt_win_trap.sv
module evt_win_trap (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic arm_i,
  input  logic serve_i,
  input  logic exit_i,
  output logic req_o,
  output logic recheck_o,
  output logic exit_taken_o
);

  logic req_q, recheck_q;

  assign exit_taken_o = exit_i & req_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q     <= 1'b0;
      recheck_q <= 1'b0;
    end else begin
      recheck_q <= exit_taken_o;
      if (arm_i)                  req_q <= 1'b1;
      else if (exit_i || serve_i) req_q <= 1'b0;
    end
  end

  assign req_o     = req_q;
  assign recheck_o = recheck_q;

endmodule

// File: rtl/evt_sat_cnt.sv
module evt_sat_cnt #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);

  localparam logic [W-1:0] MAX = {W{1'b1}};

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '0;
    else if (inc_i && cnt_q != MAX) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/evt_inj_arb.sv
module evt_inj_arb
  import evt_inj_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             entry_i,
  input  logic             reinj_pend_i,
  input  logic [2:0]       reinj_type_i,
  input  logic [7:0]       reinj_vec_i,
  input  logic             exc_pend_i,
  input  logic [7:0]       exc_vec_i,
  input  logic             smi_pend_i,
  input  logic             nmi_pend_i,
  input  logic             intr_pend_i,
  input  logic [7:0]       intr_vec_i,
  input  logic             if_flag_i,
  input  logic             sti_shadow_i,
  input  logic             ss_shadow_i,
  input  logic             win_exit_i,
  output logic [31:0]      inj_word_o,
  output logic             intr_ack_o,
  output logic             smi_go_o,
  output logic             win_req_o,
  output logic             recheck_o,
  output logic [CNT_W-1:0] win_cnt_o,
  output logic [CNT_W-1:0] inj_cnt_o
);

  logic [NUM_EVT-1:0] pend, grant;
  logic               any_pend;
  logic               intr_ok, intr_go, intr_arm, smi_go;
  logic               exit_taken;
  inj_word_t          word_d, word_q;
  logic               ack_q, smi_q;

  always_comb begin
    pend            = '0;
    pend[IDX_REINJ] = reinj_pend_i;
    pend[IDX_EXC]   = exc_pend_i;
    pend[IDX_SMI]   = smi_pend_i;
    pend[IDX_NMI]   = nmi_pend_i;
    pend[IDX_INTR]  = intr_pend_i;
  end

  evt_prio_sel #(.N(NUM_EVT)) i_sel (
    .pend_i  (pend),
    .grant_o (grant),
    .any_o   (any_pend)
  );

  assign intr_ok  = if_flag_i & ~sti_shadow_i & ~ss_shadow_i;
  assign intr_go  = entry_i & grant[IDX_INTR] & intr_ok;
  assign intr_arm = entry_i & grant[IDX_INTR] & ~intr_ok;
  assign smi_go   = entry_i & grant[IDX_SMI];

  always_comb begin
    word_d = '0;
    if (any_pend) begin
      unique case (1'b1)
        grant[IDX_REINJ]: word_d = mk_word(reinj_type_i, reinj_vec_i);
        grant[IDX_EXC]:   word_d = mk_word(TY_HWEXC, exc_vec_i);
        grant[IDX_NMI]:   word_d = mk_word(TY_NMI, NMI_VEC);
        grant[IDX_INTR]:  word_d = intr_ok ? mk_word(TY_EXT, intr_vec_i) : '0;
        default:          word_d = '0;  // SMI takes no word
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q <= '0;
      ack_q  <= 1'b0;
      smi_q  <= 1'b0;
    end else begin
      ack_q <= intr_go;
      smi_q <= smi_go;
      if (entry_i) word_q <= word_d;
    end
  end

  evt_win_trap i_trap (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .arm_i        (intr_arm),
    .serve_i      (intr_go),
    .exit_i       (win_exit_i),
    .req_o        (win_req_o),
    .recheck_o    (recheck_o),
    .exit_taken_o (exit_taken)
  );

  evt_sat_cnt #(.W(CNT_W)) i_win_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .inc_i  (exit_taken),
    .cnt_o  (win_cnt_o)
  );

  evt_sat_cnt #(.W(CNT_W)) i_inj_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .inc_i  (intr_go),
    .cnt_o  (inj_cnt_o)
  );

  assign inj_word_o = word_q;
  assign intr_ack_o = ack_q;
  assign smi_go_o   = smi_q;

endmodule

// File: rtl/evt_inj_arb_chk.sv
module evt_inj_arb_chk #(
  parameter int unsigned CNT_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             entry_i,
  input logic             reinj_pend_i,
  input logic [7:0]       reinj_vec_i,
  input logic             exc_pend_i,
  input logic             if_flag_i,
  input logic             sti_shadow_i,
  input logic             ss_shadow_i,
  input logic             win_exit_i,
  input logic [31:0]      inj_word_o,
  input logic             intr_ack_o,
  input logic             smi_go_o,
  input logic             win_req_o,
  input logic             recheck_o,
  input logic [CNT_W-1:0] win_cnt_o,
  input logic [CNT_W-1:0] inj_cnt_o
);

  localparam logic [CNT_W-1:0] MAX = {CNT_W{1'b1}};

  a_r1_reinj_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    entry_i && reinj_pend_i |=> inj_word_o[31] && inj_word_o[7:0] == $past(reinj_vec_i));

  a_r2_single_take: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({intr_ack_o, smi_go_o}));

  a_r2_exc_holds_lower: assert property (@(posedge clk_i) disable iff (!rst_ni)
    entry_i && exc_pend_i |=> !intr_ack_o && !smi_go_o);

  a_r3_blocked_no_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    entry_i && (!if_flag_i || sti_shadow_i || ss_shadow_i) |=> !intr_ack_o);

  a_r5_recheck_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    recheck_o |-> $past(win_exit_i) && $past(win_req_o));

  a_r5_exit_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_exit_i && win_req_o && !entry_i |=> !win_req_o);

  a_r7_ack_word: assert property (@(posedge clk_i) disable iff (!rst_ni)
    intr_ack_o |-> inj_word_o[31] && inj_word_o[10:8] == 3'd0);

  a_r7_ack_after_entry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    intr_ack_o |-> $past(entry_i));

  a_r8_smi_no_word: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smi_go_o |-> !inj_word_o[31]);

  a_r9_inj_sat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inj_cnt_o == MAX |=> inj_cnt_o == MAX);

  a_r9_win_sat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_cnt_o == MAX |=> win_cnt_o == MAX);

  a_r11_word_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !entry_i |=> $stable(inj_word_o));

endmodule

bind evt_inj_arb evt_inj_arb_chk #(.CNT_W(CNT_W)) i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .entry_i      (entry_i),
  .reinj_pend_i (reinj_pend_i),
  .reinj_vec_i  (reinj_vec_i),
  .exc_pend_i   (exc_pend_i),
  .if_flag_i    (if_flag_i),
  .sti_shadow_i (sti_shadow_i),
  .ss_shadow_i  (ss_shadow_i),
  .win_exit_i   (win_exit_i),
  .inj_word_o   (inj_word_o),
  .intr_ack_o   (intr_ack_o),
  .smi_go_o     (smi_go_o),
  .win_req_o    (win_req_o),
  .recheck_o    (recheck_o),
  .win_cnt_o    (win_cnt_o),
  .inj_cnt_o    (inj_cnt_o)
);

// File: tb/test_evt_inj_arb.sv
`timescale 1ns/1ps
module test_evt_inj_arb;

  localparam int unsigned CNT_W = 3;
  localparam int unsigned NV    = 12;

  // pend = {reinj, exc, smi, nmi, intr}
  typedef struct packed {
    logic [4:0]  pend;
    logic        fl;
    logic        sti;
    logic        ss;
    logic [31:0] word;
    logic        ack;
    logic        smi;
    logic        win;
  } vec_t;

  // reinj: type 4 vec 0x55; exception vec 0x0E; maskable vec 0x41
  localparam vec_t TBL [NV] = '{
    '{5'b00001, 1'b1, 1'b0, 1'b0, 32'h8000_0041, 1'b1, 1'b0, 1'b0}, // R6 R7 ext
    '{5'b11111, 1'b1, 1'b0, 1'b0, 32'h8000_0455, 1'b0, 1'b0, 1'b0}, // R1 reinj
    '{5'b01111, 1'b1, 1'b0, 1'b0, 32'h8000_030E, 1'b0, 1'b0, 1'b0}, // R1 exc
    '{5'b00111, 1'b1, 1'b0, 1'b0, 32'h0000_0000, 1'b0, 1'b1, 1'b0}, // R8 smi
    '{5'b00011, 1'b1, 1'b0, 1'b0, 32'h8000_0202, 1'b0, 1'b0, 1'b0}, // R2 nmi
    '{5'b00001, 1'b0, 1'b0, 1'b0, 32'h0000_0000, 1'b0, 1'b0, 1'b1}, // R3 R4 if=0
    '{5'b00001, 1'b1, 1'b1, 1'b0, 32'h0000_0000, 1'b0, 1'b0, 1'b1}, // R3 sti
    '{5'b00001, 1'b1, 1'b0, 1'b1, 32'h0000_0000, 1'b0, 1'b0, 1'b1}, // R3 ss
    '{5'b00010, 1'b0, 1'b0, 1'b0, 32'h8000_0202, 1'b0, 1'b0, 1'b1}, // R6 nmi
    '{5'b00001, 1'b1, 1'b0, 1'b0, 32'h8000_0041, 1'b1, 1'b0, 1'b0}, // R7 clears req
    '{5'b00000, 1'b1, 1'b0, 1'b0, 32'h0000_0000, 1'b0, 1'b0, 1'b0}, // R6 none
    '{5'b01001, 1'b0, 1'b0, 1'b0, 32'h8000_030E, 1'b0, 1'b0, 1'b0}  // R4 not top
  };

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             entry_i = 1'b0;
  logic             reinj_pend_i = 1'b0;
  logic [2:0]       reinj_type_i = 3'd4;
  logic [7:0]       reinj_vec_i = 8'h55;
  logic             exc_pend_i = 1'b0;
  logic [7:0]       exc_vec_i = 8'h0E;
  logic             smi_pend_i = 1'b0;
  logic             nmi_pend_i = 1'b0;
  logic             intr_pend_i = 1'b0;
  logic [7:0]       intr_vec_i = 8'h41;
  logic             if_flag_i = 1'b1;
  logic             sti_shadow_i = 1'b0;
  logic             ss_shadow_i = 1'b0;
  logic             win_exit_i = 1'b0;
  logic [31:0]      inj_word_o;
  logic             intr_ack_o, smi_go_o, win_req_o, recheck_o;
  logic [CNT_W-1:0] win_cnt_o, inj_cnt_o;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk_i = ~clk_i;

  evt_inj_arb #(.CNT_W(CNT_W)) i_evt_inj_arb (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic set_in(input logic [4:0] p, input logic fl, input logic sti, input logic ss);
    {reinj_pend_i, exc_pend_i, smi_pend_i, nmi_pend_i, intr_pend_i} = p;
    if_flag_i = fl; sti_shadow_i = sti; ss_shadow_i = ss;
  endtask

  // one entry; returns at the negedge after the capturing edge
  task automatic do_entry(input logic [4:0] p, input logic fl, input logic sti, input logic ss,
                          input logic ex);
    @(negedge clk_i);
    set_in(p, fl, sti, ss);
    entry_i = 1'b1; win_exit_i = ex;
    @(negedge clk_i);
    entry_i = 1'b0; win_exit_i = 1'b0;
  endtask

  task automatic do_exit();
    @(negedge clk_i);
    win_exit_i = 1'b1;
    @(negedge clk_i);
    win_exit_i = 1'b0;
  endtask

  initial begin
    #(8ns * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog act=running exp=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R10 word", inj_word_o, 32'h0);
    chk("R10 flags", {28'h0, intr_ack_o, smi_go_o, win_req_o, recheck_o}, 32'h0);
    chk("R10 cnts", {26'h0, win_cnt_o, inj_cnt_o}, 32'h0);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      do_entry(TBL[i].pend, TBL[i].fl, TBL[i].sti, TBL[i].ss, 1'b0);
      chk($sformatf("R1/R6 word v%0d", i), inj_word_o, TBL[i].word);
      chk($sformatf("R2/R7 ack v%0d", i), {31'h0, intr_ack_o}, {31'h0, TBL[i].ack});
      chk($sformatf("R8 smi v%0d", i), {31'h0, smi_go_o}, {31'h0, TBL[i].smi});
      chk($sformatf("R4 win v%0d", i), {31'h0, win_req_o}, {31'h0, TBL[i].win});
    end
    chk("R9 inj count", {29'h0, inj_cnt_o}, 32'd2);

    // R7: ack lasts one cycle
    do_entry(5'b00001, 1'b1, 1'b0, 1'b0, 1'b0);
    @(negedge clk_i);
    chk("R7 ack drops", {31'h0, intr_ack_o}, 32'h0);

    // R5: exit with nothing armed
    do_exit();
    chk("R5 idle exit recheck", {31'h0, recheck_o}, 32'h0);
    chk("R5 idle exit count", {29'h0, win_cnt_o}, 32'h0);

    // R5: arm then exit
    do_entry(5'b00001, 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R4 armed", {31'h0, win_req_o}, 32'h1);
    do_exit();
    chk("R5 req cleared", {31'h0, win_req_o}, 32'h0);
    chk("R5 recheck", {31'h0, recheck_o}, 32'h1);
    chk("R9 win count", {29'h0, win_cnt_o}, 32'd1);
    @(negedge clk_i);
    chk("R5 recheck one cycle", {31'h0, recheck_o}, 32'h0);

    // R11: word holds without entry
    do_entry(5'b00010, 1'b1, 1'b0, 1'b0, 1'b0);
    set_in(5'b10000, 1'b1, 1'b0, 1'b0);
    repeat (3) @(negedge clk_i);
    chk("R11 hold", inj_word_o, 32'h8000_0202);

    // R5: arm again, then arming entry with exit in the same cycle
    do_entry(5'b00001, 1'b0, 1'b0, 1'b0, 1'b0);
    do_entry(5'b00001, 1'b0, 1'b0, 1'b0, 1'b1);
    chk("R5 arm wins", {31'h0, win_req_o}, 32'h1);
    chk("R5 recheck same", {31'h0, recheck_o}, 32'h1);
    chk("R5 count same", {29'h0, win_cnt_o}, 32'd2);

    // R9: window counter saturates
    for (int i = 0; i < 6; i++) begin
      do_exit();
      do_entry(5'b00001, 1'b0, 1'b0, 1'b0, 1'b0);
    end
    chk("R9 win sat", {29'h0, win_cnt_o}, 32'd7);
    do_exit();
    chk("R9 win stays", {29'h0, win_cnt_o}, 32'd7);

    // R9: injection counter saturates (3 so far)
    for (int i = 0; i < 6; i++) begin
      do_entry(5'b00001, 1'b1, 1'b0, 1'b0, 1'b0);
      chk("R7 ack each", {31'h0, intr_ack_o}, 32'h1);
    end
    chk("R9 inj sat", {29'h0, inj_cnt_o}, 32'd7);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule